// File: doc/BRIEF.md
# Bit-Serial Two-Operand Adder

This block adds two unsigned operands one bit position per clock. Each operand sits in its own right-shifting register. Every cycle, the low bits of both registers go into one full adder. Its carry input comes from a single carry flop, and that flop captures the adder's carry output on every shift. The sum bit enters the A register at its most significant end, so the result builds up in place of operand A as A's bits are used up. The B register takes in zeros behind it.

A one-cycle start strobe loads both operands and clears the carry flop. A small controller then runs exactly as many shift cycles as the operand width and raises a done flag. After that, all state holds until the next strobe. A strobe that arrives during an addition drops the work in progress and starts again with the operands present on that edge. The sum is read from the A register and the final carry from the carry flop.

Top module: `serial_adder`

## Requirements
- R1: While `rst` is high at a rising edge, the next outputs are `sum`=0, `carry_out`=0 and `done`=0.
- R2: A rising edge with `go` high loads `op_a` into the A register, loads `op_b` into the B register and clears the carry flop. After that edge, `sum` equals the loaded `op_a`, `carry_out` is 0 and `done` is 0.
- R3: After a load, exactly W shift edges follow. `done` stays 0 after shift edges 1 to W-1 and becomes 1 after shift edge W.
- R4: When `done` rises, `sum` equals (op_a + op_b) mod 2^W and `carry_out` equals bit W of op_a + op_b, for the operands from the loading edge.
- R5: While `done` is 1 and `go` is low, `sum`, `carry_out` and `done` keep their values on every edge.
- R6: A `go` strobe during the shift sequence abandons the current addition. The new operands are loaded, and the new result appears W shift edges later.
- R7: Each shift moves the A register right by one and writes the new sum bit into bit W-1. After the first shift, `sum[W-1]` equals op_a[0] XOR op_b[0] and `sum[W-2:0]` equals op_a[W-1:1].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Start strobe: loads operands, clears carry, restarts the sequence |
| op_a | input | W | Parallel operand A |
| op_b | input | W | Parallel operand B |
| sum | output | W | Contents of the A register; holds the sum once done |
| carry_out | output | 1 | Carry flop; holds the final carry once done |
| done | output | 1 | High from the last shift until the next load or reset |

## Verification
The checker assumes that `op_a` and `op_b` are valid on the edge where `go` is sampled high. It does not need them to stay stable afterwards, because it records their sum on that edge. It also assumes that `go` and `rst` are never X. The bench changes inputs only on falling edges and holds the operands steady across each loading edge. For the abort test, it deliberately changes the operands during an addition so that the new result differs from the one that was abandoned.

// File: rtl/serial_adder_pkg.sv
package serial_adder_pkg;
  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_t;

  // width of a counter that must reach n-1 (at least one bit)
  function automatic int cnt_bits(input int n);
    return (n > 2) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/operand_shreg.sv
module operand_shreg #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         shift,
  input  logic [W-1:0] pdata,
  input  logic         ser_in,
  output logic [W-1:0] q,
  output logic         lsb
);
  always_ff @(posedge clk) begin
    if (rst)        q <= '0;
    else if (load)  q <= pdata;
    else if (shift) q <= {ser_in, q[W-1:1]};
  end

  assign lsb = q[0];
endmodule

// File: rtl/bit_full_adder.sv
module bit_full_adder (
  input  logic x,
  input  logic y,
  input  logic cin,
  output logic s,
  output logic cout
);
  always_comb begin
    s    = x ^ y ^ cin;
    cout = (x & y) | (cin & (x ^ y));
  end
endmodule

// File: rtl/shift_sequencer.sv
module shift_sequencer
  import serial_adder_pkg::*;
#(
  parameter int W = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic go,
  output logic load,
  output logic shift,
  output logic done
);
  localparam int CW = cnt_bits(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  seq_state_t    state;
  logic [CW-1:0] cnt;

  assign load  = go;
  assign shift = (state == SEQ_RUN) && !go;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= SEQ_IDLE;
      cnt   <= '0;
      done  <= 1'b0;
    end else if (go) begin
      state <= SEQ_RUN;
      cnt   <= '0;
      done  <= 1'b0;
    end else if (state == SEQ_RUN) begin
      if (cnt == LAST) begin
        state <= SEQ_IDLE;
        cnt   <= '0;
        done  <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/serial_adder.sv
module serial_adder #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         go,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  output logic [W-1:0] sum,
  output logic         carry_out,
  output logic         done
);
  logic         load, shift;
  logic         a_lsb, b_lsb, s_bit, c_next, cy;
  logic [W-1:0] a_q, b_q;

  shift_sequencer #(.W(W)) u_seq (
    .clk(clk), .rst(rst), .go(go),
    .load(load), .shift(shift), .done(done)
  );

  operand_shreg #(.W(W)) u_areg (
    .clk(clk), .rst(rst), .load(load), .shift(shift),
    .pdata(op_a), .ser_in(s_bit), .q(a_q), .lsb(a_lsb)
  );

  operand_shreg #(.W(W)) u_breg (
    .clk(clk), .rst(rst), .load(load), .shift(shift),
    .pdata(op_b), .ser_in(1'b0), .q(b_q), .lsb(b_lsb)
  );

  bit_full_adder u_fa (
    .x(a_lsb), .y(b_lsb), .cin(cy), .s(s_bit), .cout(c_next)
  );

  always_ff @(posedge clk) begin
    if (rst || load) cy <= 1'b0;
    else if (shift)  cy <= c_next;
  end

  assign sum       = a_q;
  assign carry_out = cy;

  logic unused_b;
  assign unused_b = ^b_q[W-1:1];
endmodule

// File: rtl/serial_adder_chk.sv
module serial_adder_chk #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         rst,
  input logic         go,
  input logic [W-1:0] op_a,
  input logic [W-1:0] op_b,
  input logic [W-1:0] sum,
  input logic         carry_out,
  input logic         done
);
  localparam int SW = $clog2(W + 2);
  localparam logic [SW-1:0] SAT = SW'(W + 1);

  logic [SW-1:0] since_go;
  logic [W:0]    exp_total;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_go  <= SAT;
      exp_total <= '0;
    end else if (go) begin
      since_go  <= '0;
      exp_total <= {1'b0, op_a} + {1'b0, op_b};
    end else if (since_go != SAT) begin
      since_go <= since_go + 1'b1;
    end
  end

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (sum == '0 && !carry_out && !done)); // R1

  AST_LOAD_TAKES_A: assert property (@(posedge clk) disable iff (rst)
    go |=> (sum == $past(op_a) && !carry_out && !done)); // R2

  AST_NOT_DONE_EARLY: assert property (@(posedge clk) disable iff (rst)
    (since_go < SW'(W)) |-> !done); // R3

  AST_DONE_AT_W: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> (since_go == SW'(W))); // R3

  AST_RESULT_OK: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> ({carry_out, sum} == exp_total)); // R4

  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (done && !go) |=> (done && $stable(sum) && $stable(carry_out))); // R5
endmodule

bind serial_adder serial_adder_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .go(go), .op_a(op_a), .op_b(op_b),
  .sum(sum), .carry_out(carry_out), .done(done)
);

// File: tb/sim_serial_adder.sv
module sim_serial_adder;
  localparam int W = 4;
  localparam int NV = 10;
  localparam logic [2*W-1:0] VEC [NV] = '{
    8'h00, 8'h11, 8'h23, 8'hF1, 8'hFF, 8'h88, 8'hA5, 8'h7E, 8'h5A, 8'h96
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         go  = 1'b0;
  logic [W-1:0] op_a = '0, op_b = '0;
  logic [W-1:0] sum;
  logic         carry_out, done;
  int           errors = 0, checks = 0;

  always #5 clk = ~clk;

  serial_adder #(.W(W)) u0 (
    .clk(clk), .rst(rst), .go(go), .op_a(op_a), .op_b(op_b),
    .sum(sum), .carry_out(carry_out), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic edge1();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic start(input logic [W-1:0] a, input logic [W-1:0] b);
    op_a = a; op_b = b; go = 1'b1;
    edge1();
    go = 1'b0;
  endtask

  task automatic full_add(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W:0] tot;
    tot = {1'b0, a} + {1'b0, b};
    start(a, b);
    chk(sum == a && !carry_out && !done, "R2 load", {done, carry_out, sum}, a);
    edge1();
    chk(sum[W-1] == (a[0] ^ b[0]) && sum[W-2:0] == a[W-1:1], "R7 first shift",
        sum, {a[0] ^ b[0], a[W-1:1]});
    for (int k = 2; k < W; k++) edge1();
    chk(!done, "R3 not done after W-1 shifts", done, 0);
    edge1();
    chk(done, "R3 done after W shifts", done, 1);
    chk({carry_out, sum} == tot, "R4 result", {carry_out, sum}, tot);
    for (int k = 0; k < 3; k++) edge1();
    chk(done && {carry_out, sum} == tot, "R5 hold", {done, carry_out, sum}, {1'b1, tot});
  endtask

  initial begin
    repeat (2) edge1();
    chk(sum == '0 && !carry_out && !done, "R1 reset state", {done, carry_out, sum}, 0);
    rst = 1'b0;
    edge1();

    for (int i = 0; i < NV; i++) full_add(VEC[i][2*W-1:W], VEC[i][W-1:0]);

    // R6: restart in the middle of an addition
    start(4'hF, 4'hF);
    edge1(); edge1();
    chk(!done, "R6 busy before abort", done, 0);
    start(4'h3, 4'h4);
    chk(sum == 4'h3 && !carry_out, "R6 reload", {carry_out, sum}, 4'h3);
    for (int k = 1; k < W; k++) edge1();
    chk(!done, "R6 not done early", done, 0);
    edge1();
    chk(done && sum == 4'h7 && !carry_out, "R6 new result", {done, carry_out, sum}, {2'b10, 4'h7});

    // R1: reset in the middle of an addition
    start(4'h9, 4'h9);
    edge1();
    rst = 1'b1;
    edge1();
    chk(sum == '0 && !carry_out && !done, "R1 reset mid-add", {done, carry_out, sum}, 0);
    rst = 1'b0;
    for (int k = 0; k < W + 2; k++) edge1();
    chk(sum == '0 && !done, "R1 idle after reset", {done, sum}, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule